// File: doc/BRIEF.md
# Power Button Hold Controller

This block watches a debounced power-button level together with a flag that says whether the system is currently off. From these it produces two request pulses, each one clock cycle wide: a boot request and a forced-shutdown request.

Pressing the button starts two independent hold timers. The boot timer is armed only if the system is off at the moment of the press. The shutdown timer is armed on every press, whatever the power state. A timer whose full count runs out with the button still held raises its request once. Letting go of the button cancels both timers. A lid that opens while the system is off asks for boot straight away. If the power sequencer reports that the system is entering suspend while a held button still has its shutdown timer pending, the shutdown request is raised at once.

Debouncing, the power state machine and rail control belong to neighbouring blocks. Both delays are parameters counted in clock ticks, and each must be at least one.

Top module: `pwrkey_hold_ctrl`

## Requirements
- R1: After reset both request outputs are low. A button or lid that is already high when reset ends is not treated as a press or an opening: the bench holds the button through reset for longer than SHUT_TICKS and expects no request.
- R2: If `key_held` is first sampled high at clock edge E0 while `sys_off` is 1, and stays high, `boot_req` goes high after edge E0+BOOT_TICKS.
- R3: A press sampled while `sys_off` is 0 never produces `boot_req`.
- R4: A press in either power state that is held continuously produces `shutdown_req` after edge E0+SHUT_TICKS.
- R5: If `key_held` is sampled low at or before the expiry edge of a timer, that timer is cancelled and emits nothing. Any edge that samples `key_held` low is followed by a cycle with `shutdown_req` low, and by a cycle with `boot_req` low unless the lid opened while the system was off.
- R6: A hold that begins while the system is off gives `boot_req` at offset BOOT_TICKS and then `shutdown_req` at offset SHUT_TICKS, both counted from the same press edge.
- R7: When `lid_open` goes from 0 to 1 while `sys_off` is 1, `boot_req` is high in the cycle after the first edge that samples the lid open. An opening while the system is on, or a lid that simply stays open, requests nothing.
- R8: If `suspend_entry` is sampled high while the button is held and its shutdown timer is pending, `shutdown_req` is high in the next cycle and the pending timer is cancelled.
- R9: During one continuous hold, each request is raised at most once.
- R10: A new press after a release restarts both timers from their full values.
- R11: Every request is exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_held | input | 1 | Debounced button level, 1 = pressed |
| sys_off | input | 1 | 1 while the system is in any off state |
| lid_open | input | 1 | Lid level, 1 = open |
| suspend_entry | input | 1 | One-cycle notice that the system is entering suspend |
| boot_req | output | 1 | One-cycle boot request |
| shutdown_req | output | 1 | One-cycle forced-shutdown request |

## Verification
The hardest case to reach from the ports is a release that lands exactly on the expiry edge. It is reached by table rows whose hold length equals the delay, set against rows that hold one cycle longer, so that an off-by-one in either timer shows up. The suspend shortcut must also fire only while a timer is pending. The bench reaches it by holding the button well before pulsing `suspend_entry`, then holding past the full shutdown delay to show that the cancelled timer stays silent.

// File: rtl/pwrkey_pkg.sv
package pwrkey_pkg;

    // Bit positions in the level vector fed to the edge detector
    localparam int EDGE_KEY  = 0;
    localparam int EDGE_LID  = 1;
    localparam int NUM_EDGE  = 2;

    // Timer slots
    localparam int TMR_BOOT  = 0;
    localparam int TMR_SHUT  = 1;
    localparam int NUM_TIMER = 2;

    typedef struct packed {
        logic lid_boot;
    } top_state_t;

endpackage

// File: rtl/pwrkey_edge_det.sv
module pwrkey_edge_det #(
    parameter int               WIDTH     = 1,
    parameter logic [WIDTH-1:0] RST_LEVEL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);

    typedef struct packed {
        logic [WIDTH-1:0] lvl;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d.lvl = lvl;
        rise     = lvl & ~st_q.lvl;
    end

    // Resetting the history high means a level already high at reset is no edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl <= RST_LEVEL;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pwrkey_hold_timer.sv
module pwrkey_hold_timer #(
    parameter int unsigned TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic held,
    input  logic force_fire,
    output logic fire
);

    localparam int unsigned CW   = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LOAD = CW'(TICKS - 1);

    typedef struct packed {
        logic          armed;
        logic          fire;
        logic [CW-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (!held) begin
            // release cancels whatever is pending
            st_d.armed = 1'b0;
        end else if (force_fire && (st_q.armed || start)) begin
            st_d.fire  = 1'b1;
            st_d.armed = 1'b0;
        end else if (start) begin
            st_d.armed = 1'b1;
            st_d.cnt   = LOAD;
        end else if (st_q.armed) begin
            if (st_q.cnt == '0) begin
                st_d.fire  = 1'b1;
                st_d.armed = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire = st_q.fire;

endmodule

// File: rtl/pwrkey_hold_ctrl.sv
module pwrkey_hold_ctrl
    import pwrkey_pkg::*;
#(
    parameter int unsigned BOOT_TICKS = 320_000,
    parameter int unsigned SHUT_TICKS = 256_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_held,
    input  logic sys_off,
    input  logic lid_open,
    input  logic suspend_entry,
    output logic boot_req,
    output logic shutdown_req
);

    logic [NUM_EDGE-1:0]  lvl_vec;
    logic [NUM_EDGE-1:0]  rise_vec;
    logic [NUM_TIMER-1:0] start_vec;
    logic [NUM_TIMER-1:0] force_vec;
    logic [NUM_TIMER-1:0] fire_vec;
    logic                 press;
    logic                 lid_rise;

    top_state_t st_d, st_q;

    always_comb begin
        lvl_vec           = '0;
        lvl_vec[EDGE_KEY] = key_held;
        lvl_vec[EDGE_LID] = lid_open;
    end

    pwrkey_edge_det #(
        .WIDTH     (NUM_EDGE),
        .RST_LEVEL ({NUM_EDGE{1'b1}})
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl_vec),
        .rise  (rise_vec)
    );

    assign press    = rise_vec[EDGE_KEY];
    assign lid_rise = rise_vec[EDGE_LID];

    always_comb begin
        start_vec           = '0;
        force_vec           = '0;
        start_vec[TMR_BOOT] = press & sys_off;
        start_vec[TMR_SHUT] = press;
        force_vec[TMR_SHUT] = suspend_entry;
    end

    for (genvar g = 0; g < NUM_TIMER; g++) begin : g_tmr
        localparam int unsigned T = (g == TMR_BOOT) ? BOOT_TICKS : SHUT_TICKS;
        pwrkey_hold_timer #(
            .TICKS (T)
        ) u_tmr (
            .clk        (clk),
            .rst_n      (rst_n),
            .start      (start_vec[g]),
            .held       (key_held),
            .force_fire (force_vec[g]),
            .fire       (fire_vec[g])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.lid_boot = lid_rise & sys_off;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign boot_req     = fire_vec[TMR_BOOT] | st_q.lid_boot;
    assign shutdown_req = fire_vec[TMR_SHUT];

endmodule

// File: rtl/pwrkey_hold_chk.sv
module pwrkey_hold_chk (
    input logic clk,
    input logic rst_n,
    input logic key_held,
    input logic sys_off,
    input logic lid_open,
    input logic suspend_entry,
    input logic boot_req,
    input logic shutdown_req
);

    logic key_prev;
    logic pend;
    logic sd_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_prev <= 1'b1;
            pend     <= 1'b0;
            sd_seen  <= 1'b0;
        end else begin
            key_prev <= key_held;
            if (!key_held) begin
                pend    <= 1'b0;
                sd_seen <= 1'b0;
            end else begin
                if (!key_prev) pend <= 1'b1;
                else if (shutdown_req || suspend_entry) pend <= 1'b0;
                if (shutdown_req) sd_seen <= 1'b1;
            end
        end
    end

    p_release_sd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !key_held |=> !shutdown_req);

    p_release_boot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_held && !(lid_open && sys_off)) |=> !boot_req);

    p_suspend_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend_entry && key_held && key_prev && pend && !shutdown_req) |=> shutdown_req);

    p_once_per_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_seen && key_held) |-> !shutdown_req);

    p_single_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> !shutdown_req);

endmodule

bind pwrkey_hold_ctrl pwrkey_hold_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .key_held      (key_held),
    .sys_off       (sys_off),
    .lid_open      (lid_open),
    .suspend_entry (suspend_entry),
    .boot_req      (boot_req),
    .shutdown_req  (shutdown_req)
);

// File: tb/sim_pwrkey_hold_ctrl.sv
module sim_pwrkey_hold_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int BT = 20;
    localparam int ST = 100;
    localparam int NROW = 8;
    localparam logic [15:0] NONE = 16'hFFFF;

    // row: {sys_off, hold cycles, expected boot offset, expected shutdown offset}
    localparam logic [48:0] VEC [0:NROW-1] = '{
        {1'b1, 16'd30,  16'd20, NONE},    // R2 boot after hold
        {1'b1, 16'd20,  NONE,   NONE},    // R5 release on boot expiry edge
        {1'b1, 16'd21,  16'd20, NONE},    // R2 one cycle longer
        {1'b0, 16'd30,  NONE,   NONE},    // R3 press while on
        {1'b0, 16'd101, NONE,   16'd100}, // R4 shutdown while on
        {1'b0, 16'd100, NONE,   NONE},    // R5 release on shutdown expiry edge
        {1'b1, 16'd150, 16'd20, 16'd100}, // R6 R9 boot then shutdown, once each
        {1'b0, 16'd5,   NONE,   NONE}     // R5 short tap
    };

    logic clk = 1'b0;
    logic rst_n;
    logic key_held, sys_off, lid_open, suspend_entry;
    logic boot_req, shutdown_req;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrkey_hold_ctrl #(.BOOT_TICKS(BT), .SHUT_TICKS(ST)) u0 (
        .clk(clk), .rst_n(rst_n), .key_held(key_held), .sys_off(sys_off),
        .lid_open(lid_open), .suspend_entry(suspend_entry),
        .boot_req(boot_req), .shutdown_req(shutdown_req)
    );

    function automatic string row_tag(input int r);
        case (r)
            0, 2:    return "R2";
            1, 5, 7: return "R5";
            3:       return "R3";
            4:       return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // press at the next edge, keep held for `hold` edges, observe 6 more cycles
    task automatic run_hold(input bit off, input int hold,
                            output int b_at, output int b_cnt,
                            output int s_at, output int s_cnt);
        b_at = -1; b_cnt = 0; s_at = -1; s_cnt = 0;
        @(negedge clk);
        sys_off  = off;
        key_held = 1'b1;
        for (int k = 0; k < hold + 6; k++) begin
            tick();
            if (boot_req) begin
                if (b_at < 0) b_at = k;
                b_cnt++;
            end
            if (shutdown_req) begin
                if (s_at < 0) s_at = k;
                s_cnt++;
            end
            if (k == hold - 1) key_held = 1'b0;
        end
        repeat (3) tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int b_at, b_cnt, s_at, s_cnt, cnt;
        rst_n = 1'b0; key_held = 1'b1; sys_off = 1'b1; lid_open = 1'b1; suspend_entry = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(!boot_req && !shutdown_req, "R1 reset outputs", {boot_req, shutdown_req}, 0);

        // R1: button and lid high through reset are not edges
        cnt = 0;
        for (int k = 0; k < ST + 20; k++) begin
            tick();
            cnt += int'(boot_req) + int'(shutdown_req);
        end
        check(cnt == 0, "R1 held through reset", cnt, 0);
        key_held = 1'b0; lid_open = 1'b0;
        repeat (3) tick();

        // table walk: R2 R3 R4 R5 R6 R9 R11
        for (int r = 0; r < NROW; r++) begin
            int eb, es;
            eb = (VEC[r][31:16] == NONE) ? -1 : int'(VEC[r][31:16]);
            es = (VEC[r][15:0]  == NONE) ? -1 : int'(VEC[r][15:0]);
            run_hold(VEC[r][48], int'(VEC[r][47:32]), b_at, b_cnt, s_at, s_cnt);
            check(b_at == eb, {row_tag(r), " boot offset"}, b_at, eb);
            check(s_at == es, {row_tag(r), " shutdown offset"}, s_at, es);
            check(b_cnt == ((eb < 0) ? 0 : 1), "R11 R9 boot pulse cycles", b_cnt, (eb < 0) ? 0 : 1);
            check(s_cnt == ((es < 0) ? 0 : 1), "R11 R9 shutdown pulse cycles", s_cnt, (es < 0) ? 0 : 1);
        end

        // R7: lid opening while off
        sys_off  = 1'b1;
        lid_open = 1'b1;
        tick();
        check(boot_req == 1'b1, "R7 lid boot", boot_req, 1);
        tick();
        check(boot_req == 1'b0, "R11 lid pulse width", boot_req, 0);
        cnt = 0;
        repeat (8) begin tick(); cnt += int'(boot_req); end
        check(cnt == 0, "R7 lid stays open", cnt, 0);
        lid_open = 1'b0;
        sys_off  = 1'b0;
        repeat (2) tick();
        lid_open = 1'b1;
        cnt = 0;
        repeat (4) begin tick(); cnt += int'(boot_req); end
        check(cnt == 0, "R7 lid open while on", cnt, 0);
        lid_open = 1'b0;
        repeat (2) tick();

        // R8: suspend while held and pending
        key_held = 1'b1;
        cnt = 0;
        repeat (30) begin tick(); cnt += int'(shutdown_req); end
        check(cnt == 0, "R8 nothing before suspend", cnt, 0);
        suspend_entry = 1'b1;
        tick();
        suspend_entry = 1'b0;
        check(shutdown_req == 1'b1, "R8 immediate shutdown", shutdown_req, 1);
        cnt = 0;
        repeat (ST + 20) begin tick(); cnt += int'(shutdown_req); end
        check(cnt == 0, "R8 R9 timer cancelled", cnt, 0);
        key_held = 1'b0;
        repeat (3) tick();

        // R10: restart from full value after release
        key_held = 1'b1;
        repeat (60) tick();
        key_held = 1'b0;
        repeat (3) tick();
        run_hold(1'b0, ST + 10, b_at, b_cnt, s_at, s_cnt);
        check(s_at == ST, "R10 restart shutdown offset", s_at, ST);
        check(s_cnt == 1, "R10 restart pulse count", s_cnt, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule